// File: doc/BRIEF.md
# Descriptor Ring Channel Controller

This block is the control side of one channel of a copy engine. It keeps track of two circular descriptor rings: a source ring that software fills with buffers to send, and a destination ring that software fills with empty buffers to receive into. Software programs base addresses, ring sizes, watermarks, a control word and a command word, and moves the write indices, all through a 32-bit register port. The engine side consumes descriptors through a valid/ready handshake per ring. Every accepted handshake advances that ring's hardware read index by one, modulo the ring size.

The block works out ring occupancy with power-of-two modular arithmetic. It raises host interrupt status for copy completion and for low and high occupancy watermarks. It raises a separate misc status for index overflow, length violations, a misaligned destination base and an engine bus error. Status bits are cleared by writing one. A single interrupt output combines the enabled bits. A halt command stops both handshakes and reports a halt status. Fetching descriptors and moving or byte-swapping data belong to the engine and are outside this block.

Top module: `dring_ctrl`

## Requirements
- R1: After reset, both write indices and both read indices are 0, both sizes read as RST_ENTRIES, host and misc status are 0, the command register reads 0, and `irq` is 0.
- R2: Each register reads back what was written at its channel offset: 0x00 source base, 0x04 source size, 0x08 destination base, 0x0C destination size, 0x10 control, 0x18 command, 0x2C host enable, 0x30 host status, 0x34 misc enable, 0x38 misc status, 0x3C source write index, 0x40 destination write index, 0x44 source read index, 0x48 destination read index, 0x4C source watermark, 0x50 destination watermark. The control register keeps only bits 18:0, so a write of 0xFFFFFFFF reads 0x0007FFFF. `reg_rdata` holds the register addressed in the previous cycle.
- R3: A write index write is accepted only if, masked to size−1, its distance ahead of the read index is at least the current one. Otherwise the index keeps its value and misc status bit 5 (source) or bit 6 (destination) is set.
- R4: A ring's ready is high exactly when it is not halted and its write and read indices differ. Each accepted handshake (valid and ready) advances the read index by one, modulo the size. A valid on an empty ring changes nothing.
- R5: Indices wrap: with size 8, read index 5 and write index 4 hold 7 entries, and seven handshakes bring the read index to 4.
- R6: Whenever a ring's index changes, occupancy is computed as (write − read) AND (size − 1). The high watermark status is set if occupancy is above the high threshold (watermark bits 15:0), and the low watermark status is set if it is below the low threshold (bits 31:16). The host status bits are: bit 1 source high, bit 2 source low, bit 3 destination high, bit 4 destination low.
- R7: Host status bit 0 (copy complete) is set by each accepted destination handshake and not by source handshakes.
- R8: Misc status bit 7 is set when a destination handshake carries a length above control bits 15:0. Bit 8 is set when a source handshake carries length 0. Bit 9 is set when a destination handshake occurs while destination base bits 2:0 are nonzero. Bit 10 is set by a pulse on `bus_err`.
- R9: Writing one to a host or misc status bit clears it, writing zero leaves it, and a set in the same cycle wins.
- R10: `irq` is high one cycle after any status bit is set together with its enable bit: host enable bits 4:0 and misc enable bits 10:5.
- R11: Command bit 0 requests a halt. Both readies drop in the cycle after the write, and command bit 3 reads 1 from the following cycle. While halted, the read indices do not move. Clearing bit 0 resumes.
- R12: `src_swap` and `dst_swap` follow control bits 16 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| src_vld | input | 1 | Engine consumed a source descriptor |
| src_rdy | output | 1 | Source ring has a descriptor and is not halted |
| src_len | input | 16 | Length reported with the source handshake |
| src_rd_idx | output | IW | Source hardware read index |
| src_swap | output | 1 | Source byte-swap enable |
| dst_vld | input | 1 | Engine completed a destination descriptor |
| dst_rdy | output | 1 | Destination ring has a buffer and is not halted |
| dst_len | input | 16 | Length reported with the destination handshake |
| dst_rd_idx | output | IW | Destination hardware read index |
| dst_swap | output | 1 | Destination byte-swap enable |
| bus_err | input | 1 | Engine bus error pulse |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions check, on every cycle, that a halted ring's read index holds, that an accepted handshake steps the read index by exactly one modulo the size, that a rejected write index leaves the index unchanged, that write-one-to-clear takes effect, that `irq` follows the enabled status with one cycle of delay, and that halt status follows the request. Only the bench scenarios can show the register map and control mask, watermark thresholds against real occupancy counts, the index wrap, which events set which misc bit, and that a valid on an empty or halted ring is dropped.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int LEN_W = 16;
  localparam int HOST_W = 5;
  localparam int MISC_W = 6;
  localparam int MISC_LSB = 5;
  localparam int CTRL_W = 19;

  localparam logic [7:0] A_SBASE = 8'h00;
  localparam logic [7:0] A_SSIZE = 8'h04;
  localparam logic [7:0] A_DBASE = 8'h08;
  localparam logic [7:0] A_DSIZE = 8'h0C;
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_CMD   = 8'h18;
  localparam logic [7:0] A_HIE   = 8'h2C;
  localparam logic [7:0] A_HIS   = 8'h30;
  localparam logic [7:0] A_MIE   = 8'h34;
  localparam logic [7:0] A_MIS   = 8'h38;
  localparam logic [7:0] A_SWR   = 8'h3C;
  localparam logic [7:0] A_DWR   = 8'h40;
  localparam logic [7:0] A_SRD   = 8'h44;
  localparam logic [7:0] A_DRD   = 8'h48;
  localparam logic [7:0] A_SWM   = 8'h4C;
  localparam logic [7:0] A_DWM   = 8'h50;

  localparam int CMD_HALT_BIT = 0;
  localparam int CMD_HSTAT_BIT = 3;
  localparam int CTRL_SSWAP_BIT = 16;
  localparam int CTRL_DSWAP_BIT = 17;
endpackage

// File: rtl/dring_ring.sv
module dring_ring #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] size,
  input  logic          wr_wen,
  input  logic [IW-1:0] wr_data,
  input  logic [IW-1:0] wm_low,
  input  logic [IW-1:0] wm_high,
  input  logic          halt,
  input  logic          eng_vld,
  output logic          eng_rdy,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          ovf,
  output logic          adv,
  output logic          lo_hit,
  output logic          hi_hit
);
  logic [IW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [IW-1:0] mask, new_wr, cur_pend, new_pend, occ_n;
  logic          wr_ok, wr_take, chg;

  always_comb begin
    mask     = size - IW'(1);
    new_wr   = wr_data & mask;
    cur_pend = (wr_q - rd_q) & mask;
    new_pend = (new_wr - rd_q) & mask;
    wr_ok    = new_pend >= cur_pend;
    wr_take  = wr_wen && wr_ok;
    eng_rdy  = !halt && (wr_q != rd_q);
    adv      = eng_vld && eng_rdy;
    rd_n     = adv ? ((rd_q + IW'(1)) & mask) : rd_q;
    wr_n     = wr_take ? new_wr : wr_q;
    occ_n    = (wr_n - rd_n) & mask;
    chg      = adv || wr_take;
    ovf      = wr_wen && !wr_ok;
    lo_hit   = chg && (occ_n < wm_low);
    hi_hit   = chg && (occ_n > wm_high);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_idx = wr_q;
  assign rd_idx = rd_q;

  // R11: a halted ring never moves its read index
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(rd_q));
  // R4: an accepted handshake steps the read index by one, modulo size
  p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_vld && !halt && (wr_q != rd_q)) |=> (rd_q == (($past(rd_q) + IW'(1)) & $past(mask))));
  // R3: a rejected write index leaves the index where it was
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(wr_q));
endmodule

// File: rtl/dring_irq.sv
module dring_irq #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_wen,
  input  logic [W-1:0] clr_data,
  input  logic         ie_wen,
  input  logic [W-1:0] ie_data,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         irq
);
  logic [W-1:0] st_q, ie_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      ie_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~(clr_wen ? clr_data : '0)) | set;
      if (ie_wen) ie_q <= ie_data;
      irq_q <= |(st_q & ie_q);
    end
  end

  assign status = st_q;
  assign enable = ie_q;
  assign irq    = irq_q;

  // R9: written ones clear unless set in the same cycle
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    clr_wen |=> ((st_q & $past(clr_data & ~set)) == '0));
  // R10: interrupt follows enabled status one cycle later
  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == $past(|(st_q & ie_q))));
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 8,
  parameter int RST_ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wen,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             src_vld,
  output logic             src_rdy,
  input  logic [LEN_W-1:0] src_len,
  output logic [IW-1:0]    src_rd_idx,
  output logic             src_swap,
  input  logic             dst_vld,
  output logic             dst_rdy,
  input  logic [LEN_W-1:0] dst_len,
  output logic [IW-1:0]    dst_rd_idx,
  output logic             dst_swap,
  input  logic             bus_err,
  output logic             irq
);
  localparam logic [7:0] RING_WR_ADDR [2] = '{A_SWR, A_DWR};

  logic [31:0]       sbase, dbase, swm, dwm;
  logic [IW-1:0]     ssize, dsize;
  logic [CTRL_W-1:0] ctrl;
  logic              halt_req, halted;
  logic [7:0]        addr8;

  logic [IW-1:0] r_size [2];
  logic [IW-1:0] r_low  [2];
  logic [IW-1:0] r_high [2];
  logic [IW-1:0] r_wr   [2];
  logic [IW-1:0] r_rd   [2];
  logic          r_vld  [2];
  logic          r_rdy  [2];
  logic          r_ovf  [2];
  logic          r_adv  [2];
  logic          r_lo   [2];
  logic          r_hi   [2];

  logic [HOST_W-1:0] h_set, h_st, h_ie;
  logic [MISC_W-1:0] m_set, m_st, m_ie;
  logic              h_irq, m_irq;

  assign addr8 = 8'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sbase    <= '0;
      dbase    <= '0;
      swm      <= '0;
      dwm      <= '0;
      ssize    <= IW'(RST_ENTRIES);
      dsize    <= IW'(RST_ENTRIES);
      ctrl     <= '0;
      halt_req <= 1'b0;
      halted   <= 1'b0;
    end else begin
      halted <= halt_req;
      if (reg_wen) begin
        case (addr8)
          A_SBASE: sbase    <= reg_wdata;
          A_DBASE: dbase    <= reg_wdata;
          A_SSIZE: ssize    <= reg_wdata[IW-1:0];
          A_DSIZE: dsize    <= reg_wdata[IW-1:0];
          A_CTRL:  ctrl     <= reg_wdata[CTRL_W-1:0];
          A_CMD:   halt_req <= reg_wdata[CMD_HALT_BIT];
          A_SWM:   swm      <= reg_wdata;
          A_DWM:   dwm      <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign r_size[0] = ssize;
  assign r_size[1] = dsize;
  assign r_low[0]  = IW'(swm[31:16]);
  assign r_high[0] = IW'(swm[15:0]);
  assign r_low[1]  = IW'(dwm[31:16]);
  assign r_high[1] = IW'(dwm[15:0]);
  assign r_vld[0]  = src_vld;
  assign r_vld[1]  = dst_vld;

  for (genvar g = 0; g < 2; g++) begin : g_ring
    dring_ring #(.IW(IW)) u_ring (
      .clk     (clk),
      .rst     (rst),
      .size    (r_size[g]),
      .wr_wen  (reg_wen && (addr8 == RING_WR_ADDR[g])),
      .wr_data (reg_wdata[IW-1:0]),
      .wm_low  (r_low[g]),
      .wm_high (r_high[g]),
      .halt    (halt_req),
      .eng_vld (r_vld[g]),
      .eng_rdy (r_rdy[g]),
      .wr_idx  (r_wr[g]),
      .rd_idx  (r_rd[g]),
      .ovf     (r_ovf[g]),
      .adv     (r_adv[g]),
      .lo_hit  (r_lo[g]),
      .hi_hit  (r_hi[g])
    );
  end

  // host bits: 0 copy, 1 src high, 2 src low, 3 dst high, 4 dst low
  assign h_set = {r_lo[1], r_hi[1], r_lo[0], r_hi[0], r_adv[1]};
  // misc bits 5..10: src ovf, dst ovf, dst max len, src len, dst addr, bus
  assign m_set = {bus_err,
                  r_adv[1] && (dbase[2:0] != 3'b000),
                  r_adv[0] && (src_len == '0),
                  r_adv[1] && (dst_len > ctrl[15:0]),
                  r_ovf[1], r_ovf[0]};

  dring_irq #(.W(HOST_W)) u_host (
    .clk      (clk),
    .rst      (rst),
    .set      (h_set),
    .clr_wen  (reg_wen && (addr8 == A_HIS)),
    .clr_data (reg_wdata[HOST_W-1:0]),
    .ie_wen   (reg_wen && (addr8 == A_HIE)),
    .ie_data  (reg_wdata[HOST_W-1:0]),
    .status   (h_st),
    .enable   (h_ie),
    .irq      (h_irq)
  );

  dring_irq #(.W(MISC_W)) u_misc (
    .clk      (clk),
    .rst      (rst),
    .set      (m_set),
    .clr_wen  (reg_wen && (addr8 == A_MIS)),
    .clr_data (reg_wdata[MISC_LSB+MISC_W-1:MISC_LSB]),
    .ie_wen   (reg_wen && (addr8 == A_MIE)),
    .ie_data  (reg_wdata[MISC_LSB+MISC_W-1:MISC_LSB]),
    .status   (m_st),
    .enable   (m_ie),
    .irq      (m_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (addr8)
        A_SBASE: reg_rdata <= sbase;
        A_SSIZE: reg_rdata <= 32'(ssize);
        A_DBASE: reg_rdata <= dbase;
        A_DSIZE: reg_rdata <= 32'(dsize);
        A_CTRL:  reg_rdata <= 32'(ctrl);
        A_CMD:   reg_rdata <= 32'({halted, 2'b00, halt_req});
        A_HIE:   reg_rdata <= 32'(h_ie);
        A_HIS:   reg_rdata <= 32'(h_st);
        A_MIE:   reg_rdata <= 32'({m_ie, 5'b00000});
        A_MIS:   reg_rdata <= 32'({m_st, 5'b00000});
        A_SWR:   reg_rdata <= 32'(r_wr[0]);
        A_DWR:   reg_rdata <= 32'(r_wr[1]);
        A_SRD:   reg_rdata <= 32'(r_rd[0]);
        A_DRD:   reg_rdata <= 32'(r_rd[1]);
        A_SWM:   reg_rdata <= swm;
        A_DWM:   reg_rdata <= dwm;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign src_rdy    = r_rdy[0];
  assign dst_rdy    = r_rdy[1];
  assign src_rd_idx = r_rd[0];
  assign dst_rd_idx = r_rd[1];
  assign src_swap   = ctrl[CTRL_SSWAP_BIT];
  assign dst_swap   = ctrl[CTRL_DSWAP_BIT];
  assign irq        = h_irq || m_irq;

  // R11: halt status follows the request one cycle later
  p_halt_status_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req) |=> halted);
  // R11: no ring offers a descriptor while halt is requested
  p_halt_rdy_r11: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> !(src_rdy || dst_rdy));
endmodule

// File: tb/dring_ctrl_test.sv
module dring_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_vld = 1'b0, dst_vld = 1'b0, bus_err = 1'b0;
  logic        src_rdy, dst_rdy, src_swap, dst_swap, irq;
  logic [15:0] src_len = '0, dst_len = '0;
  logic [15:0] src_rd_idx, dst_rd_idx;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  dring_ctrl uut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_vld(src_vld), .src_rdy(src_rdy), .src_len(src_len),
    .src_rd_idx(src_rd_idx), .src_swap(src_swap),
    .dst_vld(dst_vld), .dst_rdy(dst_rdy), .dst_len(dst_len),
    .dst_rd_idx(dst_rd_idx), .dst_swap(dst_swap),
    .bus_err(bus_err), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic src_hs(input logic [15:0] len);
    @(negedge clk);
    src_vld = 1'b1; src_len = len;
    @(negedge clk);
    src_vld = 1'b0;
  endtask

  task automatic dst_hs(input logic [15:0] len);
    @(negedge clk);
    dst_vld = 1'b1; dst_len = len;
    @(negedge clk);
    dst_vld = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 source size", d, 32'd8);
    rd(8'h0C, d); chk("R1 destination size", d, 32'd8);
    rd(8'h30, d); chk("R1 host status", d, 0);
    rd(8'h38, d); chk("R1 misc status", d, 0);
    rd(8'h44, d); chk("R1 source read index", d, 0);
    rd(8'h18, d); chk("R1 command", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'h0000_1000);
    rd(8'h00, d); chk("R2 source base", d, 32'h1000);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R2 control mask", d, 32'h0007_FFFF);
    chk("R12 src_swap set", 32'(src_swap), 1);
    chk("R12 dst_swap set", 32'(dst_swap), 1);
    wr(8'h10, 32'h0000_0040);
    chk("R12 src_swap clear", 32'(src_swap), 0);
    chk("R12 dst_swap clear", 32'(dst_swap), 0);
  endtask

  task automatic t_src();
    logic [31:0] d;
    wr(8'h04, 32'd8);
    wr(8'h4C, 32'h0002_0003);
    wr(8'h3C, 32'd5);
    rd(8'h30, d); chk("R6 source high watermark", d, 32'h2);
    for (int i = 0; i < 5; i++) src_hs(16'd4);
    rd(8'h44, d); chk("R4 source read index", d, 32'd5);
    rd(8'h30, d); chk("R6 source low watermark, R7 no copy on source", d, 32'h6);
    chk("R4 ready low when empty", 32'(src_rdy), 0);
    src_hs(16'd4);
    rd(8'h44, d); chk("R4 valid on empty ignored", d, 32'd5);
    wr(8'h30, 32'h6);
    rd(8'h30, d); chk("R9 write one clears", d, 0);
  endtask

  task automatic t_ovf_wrap();
    logic [31:0] d;
    wr(8'h3C, 32'd4);
    wr(8'h3C, 32'd2);
    rd(8'h38, d); chk("R3 source overflow bit 5", d, 32'h20);
    rd(8'h3C, d); chk("R3 rejected write kept", d, 32'd4);
    for (int i = 0; i < 7; i++) src_hs(16'd4);
    rd(8'h44, d); chk("R5 read index wrapped", d, 32'd4);
    wr(8'h30, 32'h1F);
    wr(8'h38, 32'h20);
    rd(8'h38, d); chk("R9 misc cleared", d, 0);
  endtask

  task automatic t_dst();
    logic [31:0] d;
    wr(8'h08, 32'h0000_2000);
    wr(8'h0C, 32'd4);
    wr(8'h40, 32'd3);
    dst_hs(16'd100);
    rd(8'h38, d); chk("R8 max length violation bit 7", d, 32'h80);
    rd(8'h30, d); chk("R7 copy complete", d & 32'h1, 32'h1);
    wr(8'h38, 32'h80);
    dst_hs(16'd64);
    rd(8'h38, d); chk("R8 length at limit allowed", d, 0);
    wr(8'h08, 32'h0000_2004);
    dst_hs(16'd8);
    wr(8'h3C, 32'd5);
    src_hs(16'd0);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
    wr(8'h40, 32'd2);
    wr(8'h40, 32'd1);
    rd(8'h38, d); chk("R8 R3 misc errors", d, 32'h740);
    rd(8'h40, d); chk("R3 destination write kept", d, 32'd2);
  endtask

  task automatic t_irq();
    chk("R10 irq off with no enables", 32'(irq), 0);
    wr(8'h34, 32'h7E0);
    repeat (2) @(negedge clk);
    chk("R10 irq from misc", 32'(irq), 1);
    wr(8'h38, 32'h7E0);
    wr(8'h34, 32'h0);
    wr(8'h30, 32'h1F);
    wr(8'h2C, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 irq cleared", 32'(irq), 0);
    dst_hs(16'd8);
    repeat (2) @(negedge clk);
    chk("R10 irq from copy complete", 32'(irq), 1);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    wr(8'h18, 32'h1);
    chk("R11 dst ready dropped", 32'(dst_rdy), 0);
    rd(8'h18, d); chk("R11 halt status", d, 32'h9);
    dst_hs(16'd8);
    rd(8'h48, d); chk("R11 read index held", d, 32'd0);
    wr(8'h18, 32'h0);
    chk("R11 resume ready", 32'(dst_rdy), 1);
    rd(8'h18, d); chk("R11 status cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_src();
    t_ovf_wrap();
    t_dst();
    t_irq();
    t_halt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1-scope run actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule